// File: doc/BRIEF.md
# Fully Associative Translation Cache with Least-Recently-Used Replacement

This block caches page translations for a processor's address path. A 20-bit virtual page number, qualified by an 8-bit address-space tag, is compared against all 64 slots at once, and on a match the block returns a 20-bit frame number together with a writable flag and a user-access flag in the same cycle. The lookup result is purely combinational. The `look_valid` strobe only marks a real access, so that the matched slot's recency is refreshed at the next clock edge.

When a lookup misses, some other agent resolves the translation and writes it back through the fill port. A fill first reuses a slot already holding the same page and tag. Failing that, it takes the lowest-numbered empty slot, and failing that it takes the slot with the oldest recency stamp. Stamps come from a 32-bit access counter. The counter advances once per effective fill and once per effective recency refresh. Slots marked global match any address-space tag. Two invalidate controls are provided. The first drops every slot holding a given page, whatever its tag. The second drops every slot that is not global.

Top module: `tlb_lru_top`

## Requirements
- R1: After synchronous reset every slot is empty, so every lookup misses.
- R2: A lookup hits only when a slot is valid, its page number equals `look_vpn`, and either its tag equals `look_asid` or the slot is global. On a hit, `hit_pfn`, `hit_wr` and `hit_usr` show the stored values in the same cycle.
- R3: When `look_valid` is high and the lookup hits, the matching slot's stamp takes the current counter value at the clock edge, and the counter then advances by one. Recently used slots are therefore evicted last.
- R4: When the page/tag pair is not already cached, a fill writes the lowest-numbered empty slot in preference to any valid slot.
- R5: When all 64 slots are valid, a fill of a new page/tag pair replaces the slot with the smallest stamp. The new slot is stamped with the counter value, and the counter then advances.
- R6: A fill whose page number and tag equal those of a valid slot overwrites that slot and evicts nothing.
- R7: Asserting `inv_page` clears every slot whose page number equals `inv_vpn`, regardless of its tag or global flag.
- R8: Asserting `inv_all` clears every slot except those marked global.
- R9: In a cycle with either invalidate asserted, a fill is dropped and no stamp is refreshed.
- R10: In a cycle with a fill, a simultaneous lookup refreshes no stamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| look_valid | input | 1 | Marks the lookup as a real access (refreshes recency) |
| look_vpn | input | 20 | Virtual page number to translate |
| look_asid | input | 8 | Address-space tag of the request |
| hit | output | 1 | Lookup matched a slot |
| hit_pfn | output | 20 | Frame number of the matched slot |
| hit_wr | output | 1 | Writable flag of the matched slot |
| hit_usr | output | 1 | User-access flag of the matched slot |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | 20 | Page number to write |
| fill_asid | input | 8 | Address-space tag to write |
| fill_pfn | input | 20 | Frame number to write |
| fill_wr | input | 1 | Writable flag to write |
| fill_usr | input | 1 | User-access flag to write |
| fill_glb | input | 1 | Global flag to write |
| inv_page | input | 1 | Invalidate all slots holding `inv_vpn` |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_all | input | 1 | Invalidate all non-global slots |

## Verification
Lookups are tried with matching and mismatching tags and with global slots, which separates tag qualification from the page compare alone. The table is filled to capacity in a known order. A refreshed slot is then shown to survive while the oldest slot is evicted, and a hole punched by an invalidate is shown to be reused before any eviction takes place. A re-fill of a cached page, and fills that coincide with an invalidate or with a lookup, are followed by probes of the next eviction candidate. These probes reveal whether an extra slot was consumed or a stamp was wrongly refreshed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VPN_W   = 20;
    localparam int PFN_W   = 20;
    localparam int ASID_W  = 8;
    localparam int STAMP_W = 32;
    localparam int ENTRIES = 64;
    localparam int IDX_W   = $clog2(ENTRIES);

    typedef logic [VPN_W-1:0]   vpn_t;
    typedef logic [PFN_W-1:0]   pfn_t;
    typedef logic [ASID_W-1:0]  asid_t;
    typedef logic [STAMP_W-1:0] stamp_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef struct packed {
        vpn_t  vpn;
        asid_t asid;
        logic  glb;
        pfn_t  pfn;
        logic  wr;
        logic  usr;
    } xlat_rec_t;

    function automatic logic rec_matches(xlat_rec_t r, vpn_t v, asid_t a);
        return (r.vpn == v) && (r.glb || (r.asid == a));
    endfunction

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
    import tlb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  xlat_rec_t load_rec,
    input  logic      touch,
    input  stamp_t    now,
    input  vpn_t      look_vpn,
    input  asid_t     look_asid,
    input  vpn_t      fill_vpn,
    input  asid_t     fill_asid,
    input  logic      inv_page,
    input  vpn_t      inv_vpn,
    input  logic      inv_all,
    output logic      look_match,
    output logic      fill_match,
    output logic      vld,
    output xlat_rec_t rec,
    output stamp_t    stamp
);

    logic kill;

    assign kill = (inv_page && (rec.vpn == inv_vpn)) || (inv_all && !rec.glb);

    always_ff @(posedge clk) begin
        if (rst)
            vld <= 1'b0;
        else if (kill)
            vld <= 1'b0;
        else if (load)
            vld <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (load) begin
            rec   <= load_rec;
            stamp <= now;
        end else if (touch) begin
            stamp <= now;
        end
    end

    assign look_match = vld && rec_matches(rec, look_vpn, look_asid);
    assign fill_match = vld && (rec.vpn == fill_vpn) && (rec.asid == fill_asid);

    AST_PAGE_GONE: assert property (@(posedge clk) disable iff (rst)
        (inv_page && vld && (rec.vpn == inv_vpn)) |=> !vld); // R7

    AST_LOAD_VALID: assert property (@(posedge clk) disable iff (rst)
        (load && !inv_page && !inv_all) |=> vld); // R4

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick
    import tlb_pkg::*;
(
    input  logic [ENTRIES-1:0] vld_vec,
    input  stamp_t             stamps [ENTRIES],
    output idx_t               victim
);

    logic   free_found;
    idx_t   free_idx;
    idx_t   old_idx;
    stamp_t old_stamp;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!vld_vec[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        old_idx   = '0;
        old_stamp = stamps[0];
        for (int i = 1; i < ENTRIES; i++) begin
            if (stamps[i] < old_stamp) begin
                old_stamp = stamps[i];
                old_idx   = IDX_W'(i);
            end
        end
    end

    assign victim = free_found ? free_idx : old_idx;

endmodule

// File: rtl/tlb_lru_top.sv
module tlb_lru_top
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              look_valid,
    input  logic [VPN_W-1:0]  look_vpn,
    input  logic [ASID_W-1:0] look_asid,
    output logic              hit,
    output logic [PFN_W-1:0]  hit_pfn,
    output logic              hit_wr,
    output logic              hit_usr,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_wr,
    input  logic              fill_usr,
    input  logic              fill_glb,
    input  logic              inv_page,
    input  logic [VPN_W-1:0]  inv_vpn,
    input  logic              inv_all
);

    logic [ENTRIES-1:0] vld_vec, glb_vec, look_hits, fill_hits, load_vec, touch_vec;
    xlat_rec_t          recs   [ENTRIES];
    stamp_t             stamps [ENTRIES];
    stamp_t             counter;
    xlat_rec_t          new_rec;
    idx_t               victim, hit_idx, dup_idx, tgt_idx;
    logic               dup_found, inv_any, fill_go, touch_go;

    assign inv_any  = inv_page || inv_all;
    assign fill_go  = fill_en && !inv_any;
    assign touch_go = look_valid && hit && !fill_en && !inv_any;

    assign new_rec = '{vpn: fill_vpn, asid: fill_asid, glb: fill_glb,
                       pfn: fill_pfn, wr: fill_wr, usr: fill_usr};

    // lowest-index lookup hit and duplicate fill target
    always_comb begin
        hit       = 1'b0;
        hit_idx   = '0;
        dup_found = 1'b0;
        dup_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_hits[i] && !hit) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (fill_hits[i] && !dup_found) begin
                dup_found = 1'b1;
                dup_idx   = IDX_W'(i);
            end
        end
    end

    assign tgt_idx = dup_found ? dup_idx : victim;
    assign hit_pfn = hit ? recs[hit_idx].pfn : '0;
    assign hit_wr  = hit && recs[hit_idx].wr;
    assign hit_usr = hit && recs[hit_idx].usr;

    always_comb begin
        load_vec  = '0;
        touch_vec = '0;
        if (fill_go)  load_vec[tgt_idx]  = 1'b1;
        if (touch_go) touch_vec[hit_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            counter <= '0;
        else if (fill_go || touch_go)
            counter <= counter + STAMP_W'(1);
    end

    tlb_pick i_pick (
        .vld_vec (vld_vec),
        .stamps  (stamps),
        .victim  (victim)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlb_slot i_slot (
            .clk        (clk),
            .rst        (rst),
            .load       (load_vec[g]),
            .load_rec   (new_rec),
            .touch      (touch_vec[g]),
            .now        (counter),
            .look_vpn   (look_vpn),
            .look_asid  (look_asid),
            .fill_vpn   (fill_vpn),
            .fill_asid  (fill_asid),
            .inv_page   (inv_page),
            .inv_vpn    (inv_vpn),
            .inv_all    (inv_all),
            .look_match (look_hits[g]),
            .fill_match (fill_hits[g]),
            .vld        (vld_vec[g]),
            .rec        (recs[g]),
            .stamp      (stamps[g])
        );
        assign glb_vec[g] = recs[g].glb;
    end

    AST_RST_EMPTY: assert property (@(posedge clk)
        rst |=> (vld_vec == '0)); // R1

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((counter == $past(counter)) || (counter == $past(counter) + STAMP_W'(1)))); // R3

    AST_INV_FREEZE: assert property (@(posedge clk) disable iff (rst)
        inv_any |=> (counter == $past(counter))); // R9

    AST_FLUSH_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        (inv_all && !inv_page) |=> ((vld_vec & ~glb_vec) == '0)); // R8

    AST_FILL_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        fill_go |=> (counter == $past(counter) + STAMP_W'(1))); // R10

    AST_HIT_FLAGS: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (hit_pfn == '0 && !hit_wr && !hit_usr)); // R2

endmodule

// File: tb/test_tlb_lru_top.sv
module test_tlb_lru_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        look_valid;
    logic [19:0] look_vpn;
    logic [7:0]  look_asid;
    logic        hit;
    logic [19:0] hit_pfn;
    logic        hit_wr, hit_usr;
    logic        fill_en;
    logic [19:0] fill_vpn;
    logic [7:0]  fill_asid;
    logic [19:0] fill_pfn;
    logic        fill_wr, fill_usr, fill_glb;
    logic        inv_page;
    logic [19:0] inv_vpn;
    logic        inv_all;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tlb_lru_top i_tlb_lru_top (.*);

    task automatic idle();
        look_valid = 0; fill_en = 0; inv_page = 0; inv_all = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic expect_hit(input logic [19:0] vpn, input logic [7:0] asid,
                              input logic exp_hit, input logic [19:0] exp_pfn,
                              input string req);
        look_vpn = vpn; look_asid = asid;
        #1;
        checks++;
        if (hit !== exp_hit || (exp_hit && hit_pfn !== exp_pfn)) begin
            fails++;
            $display("FAIL %s vpn=%h: hit=%b pfn=%h expected hit=%b pfn=%h",
                     req, vpn, hit, hit_pfn, exp_hit, exp_pfn);
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] asid,
                        input logic [19:0] pfn, input logic wr, input logic usr,
                        input logic glb);
        fill_en = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
        fill_wr = wr; fill_usr = usr; fill_glb = glb;
        tick();
    endtask

    task automatic touch(input logic [19:0] vpn, input logic [7:0] asid);
        look_valid = 1; look_vpn = vpn; look_asid = asid;
        tick();
    endtask

    task automatic t_reset();
        expect_hit(20'h0, 8'h0, 0, 0, "R1");
        expect_hit(20'h12345, 8'h3, 0, 0, "R1");
    endtask

    task automatic t_tags();
        fill(20'h12345, 8'h3, 20'hABCDE, 1, 0, 0);
        expect_hit(20'h12345, 8'h3, 1, 20'hABCDE, "R2");
        checks++;
        if (hit_wr !== 1'b1 || hit_usr !== 1'b0) begin
            fails++;
            $display("FAIL R2 flags: wr=%b usr=%b expected wr=1 usr=0", hit_wr, hit_usr);
        end
        expect_hit(20'h12345, 8'h4, 0, 0, "R2");
        fill(20'h00777, 8'h9, 20'h00055, 0, 1, 1);
        expect_hit(20'h00777, 8'h2, 1, 20'h00055, "R2");
    endtask

    task automatic t_flush();
        inv_all = 1; tick();
        expect_hit(20'h12345, 8'h3, 0, 0, "R8");
        expect_hit(20'h00777, 8'h2, 1, 20'h00055, "R8");
        inv_page = 1; inv_vpn = 20'h00777; tick();
        expect_hit(20'h00777, 8'h9, 0, 0, "R7");
    endtask

    task automatic t_lru();
        for (int i = 0; i < 64; i++) fill(20'(i), 8'h1, 20'(i + 'h100), 0, 0, 0);
        expect_hit(20'd63, 8'h1, 1, 20'h13F, "R4");
        touch(20'd0, 8'h1);
        fill(20'h400, 8'h1, 20'h0A00, 0, 0, 0);
        expect_hit(20'd1, 8'h1, 0, 0, "R5");
        expect_hit(20'd0, 8'h1, 1, 20'h100, "R3");
        expect_hit(20'h400, 8'h1, 1, 20'h0A00, "R5");
    endtask

    task automatic t_hole();
        inv_page = 1; inv_vpn = 20'd40; tick();
        fill(20'h401, 8'h1, 20'h0A01, 0, 0, 0);
        expect_hit(20'd2, 8'h1, 1, 20'h102, "R4");
        expect_hit(20'h401, 8'h1, 1, 20'h0A01, "R4");
    endtask

    task automatic t_overwrite();
        fill(20'd3, 8'h1, 20'hBEEF, 0, 0, 0);
        expect_hit(20'd2, 8'h1, 1, 20'h102, "R6");
        expect_hit(20'd3, 8'h1, 1, 20'hBEEF, "R6");
    endtask

    task automatic t_inv_vs_fill();
        inv_page = 1; inv_vpn = 20'd50;
        fill(20'h402, 8'h1, 20'h0A02, 0, 0, 0);
        expect_hit(20'h402, 8'h1, 0, 0, "R9");
        expect_hit(20'd50, 8'h1, 0, 0, "R7");
    endtask

    task automatic t_fill_vs_look();
        fill(20'h403, 8'h1, 20'h0A03, 0, 0, 0);
        look_valid = 1; look_vpn = 20'd4; look_asid = 8'h1;
        fill(20'h404, 8'h1, 20'h0A04, 0, 0, 0);
        expect_hit(20'd2, 8'h1, 0, 0, "R5");
        fill(20'h405, 8'h1, 20'h0A05, 0, 0, 0);
        expect_hit(20'd4, 8'h1, 0, 0, "R10");
        expect_hit(20'd5, 8'h1, 1, 20'h105, "R10");
        expect_hit(20'h403, 8'h1, 1, 20'h0A03, "R4");
    endtask

    initial begin
        idle();
        rst = 1; look_vpn = 0; look_asid = 0; fill_vpn = 0; fill_asid = 0;
        fill_pfn = 0; fill_wr = 0; fill_usr = 0; fill_glb = 0; inv_vpn = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_tags();
        t_flush();
        t_lru();
        t_hole();
        t_overwrite();
        t_inv_vs_fill();
        t_fill_vs_look();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule